// File: doc/BRIEF.md
# Address-Latched Cartridge Bank Mapper

This block switches program and pattern banks for an 8-bit console cartridge. When the CPU writes anywhere in the upper 32 KB of its address space, the block stores a configuration word taken from the write address. The data bus plays no part, and the block has no data input. The stored word selects four things:

- the nametable mirroring;
- whether program memory is banked as one 32 KB page or as a 16 KB half-page that appears in both 16 KB CPU windows;
- the program page number;
- the 8 KB pattern (CHR) page.

From the stored word and the live CPU and PPU addresses, the block produces the upper address lines of the program ROM and the pattern ROM, plus the line that drives VRAM A10. All three outputs are combinational from the stored state and the current addresses. A state change takes effect on the clock edge that samples the write strobe.

Parameters set the width of the program page field and the pattern page field. A build option turns CPU write-address bit 14 into an extra, most significant program page bit, for a double-size cartridge. In the default build that bit has no effect on the stored state.

Top module: `addr_bank_mapper`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first load, the state is: 32 KB mode, program page 0, pattern page 0, vertical mirroring. In that state `prg_addr` = {5'b0, cpu_a[14:0]}, `chr_addr` = {6'b0, ppu_a[12:0]} and `vram_a10` = ppu_a[10].
- R2: A load happens at a rising clock edge where `cpu_wr_stb`=1, `cpu_rw`=0 and cpu_a[15]=1. The new state drives the outputs from that edge onward.
- R3: Two kinds of access leave every output unchanged for the same `cpu_a` and `ppu_a`: a strobe with `cpu_rw`=1 (a read), and a write with cpu_a[15]=0.
- R4: Write-address bit 13 is the mirroring select. With 0, `vram_a10` = ppu_a[10] (vertical mirroring). With 1, `vram_a10` = ppu_a[11] (horizontal mirroring).
- R5: Write-address bits 11..7 are the 32 KB program page, with bit 11 as MSB. The page appears on prg_addr[19:15].
- R6: Write-address bit 12 selects the banking mode: 0 is 32 KB, 1 is 16 KB. In 16 KB mode, prg_addr[14] equals the stored write-address bit 6 for every CPU address, so the same half appears at $8000 and at $C000.
- R7: In 32 KB mode, prg_addr[14] = cpu_a[14], and write-address bit 6 has no effect.
- R8: Write-address bits 5..0 are the pattern page, with bit 5 as MSB. `chr_addr` = {page[5:0], ppu_a[12:0]}.
- R9: prg_addr[13:0] = cpu_a[13:0]. In the default build, write-address bit 14 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the write strobe |
| rst_n | input | 1 | Asynchronous active-low reset to the power-on state |
| cpu_a | input | 16 | CPU address bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_wr_stb | input | 1 | Bus-cycle strobe; a load needs it high together with a write to $8000-$FFFF |
| ppu_a | input | 13 | PPU address bits 12..0 |
| prg_addr | output | 20 | Program ROM address: {page, bank bit 14, cpu_a[13:0]} |
| chr_addr | output | 19 | Pattern ROM address: {pattern page, ppu_a[12:0]} |
| vram_a10 | output | 1 | VRAM A10 source chosen by the mirroring select |

## Verification
The assertions assume the following about the inputs:

- `cpu_wr_stb` is sampled only at the rising edge.
- `cpu_a` and `cpu_rw` are stable across that edge whenever the strobe is high.
- Reset is applied before the first strobe.

The bench drives every input on the falling edge and holds it through the next rising edge. It keeps the strobe low during reset. It mixes random loads, reads in the upper window and writes below $8000, and checks the outputs against probe addresses driven while the strobe is low.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  // Bit positions inside the captured write address; the latch decodes them.
  localparam int MIRROR_BIT = 13;
  localparam int MODE_BIT   = 12;
  localparam int PAGE_LSB   = 7;
  localparam int HALF_BIT   = 6;
  localparam int EXT_BIT    = 14;
  localparam int WIN_BIT    = 15;

  typedef enum logic {MIR_VERT = 1'b0, MIR_HORZ = 1'b1} mirror_e;
  typedef enum logic {BANK_32K = 1'b0, BANK_16K = 1'b1} bank_mode_e;

  // Nametable line: vertical uses PPU A10, horizontal uses PPU A11.
  function automatic logic pick_a10(mirror_e m, logic a10, logic a11);
    return (m == MIR_HORZ) ? a11 : a10;
  endfunction

  // Program bank bit 14: live in 32 KB mode, latched half in 16 KB mode.
  function automatic logic pick_a14(bank_mode_e md, logic half, logic live);
    return (md == BANK_16K) ? half : live;
  endfunction
endpackage

// File: rtl/mapper_decode.sv
module mapper_decode
  import mapper_pkg::*;
#(
  parameter int PAGE_BITS = 5,
  parameter int CHR_BITS  = 6,
  parameter bit WIDE_PRG  = 1'b0,
  localparam int PAGE_W   = PAGE_BITS + (WIDE_PRG ? 1 : 0)
) (
  input  logic [15:0]         wr_addr,
  output mirror_e             mir_d,
  output bank_mode_e          mode_d,
  output logic                half_d,
  output logic [PAGE_W-1:0]   page_d,
  output logic [CHR_BITS-1:0] chr_d
);
  assign mir_d  = mirror_e'(wr_addr[MIRROR_BIT]);
  assign mode_d = bank_mode_e'(wr_addr[MODE_BIT]);
  assign half_d = wr_addr[HALF_BIT];
  assign chr_d  = wr_addr[CHR_BITS-1:0];

  generate
    if (WIDE_PRG) begin : g_wide
      assign page_d = {wr_addr[EXT_BIT], wr_addr[PAGE_LSB +: PAGE_BITS]};
    end else begin : g_narrow
      assign page_d = wr_addr[PAGE_LSB +: PAGE_BITS];
    end
  endgenerate
endmodule

// File: rtl/mapper_state.sv
module mapper_state
  import mapper_pkg::*;
#(
  parameter int PAGE_W   = 5,
  parameter int CHR_BITS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  mirror_e             mir_d,
  input  bank_mode_e          mode_d,
  input  logic                half_d,
  input  logic [PAGE_W-1:0]   page_d,
  input  logic [CHR_BITS-1:0] chr_d,
  output mirror_e             mir_q,
  output bank_mode_e          mode_q,
  output logic                half_q,
  output logic [PAGE_W-1:0]   page_q,
  output logic [CHR_BITS-1:0] chr_q
);
  // Reset value equals the decode of a write to $8000.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mir_q  <= MIR_VERT;
      mode_q <= BANK_32K;
      half_q <= 1'b0;
      page_q <= '0;
      chr_q  <= '0;
    end else if (load) begin
      mir_q  <= mir_d;
      mode_q <= mode_d;
      half_q <= half_d;
      page_q <= page_d;
      chr_q  <= chr_d;
    end
  end
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
  import mapper_pkg::*;
#(
  parameter int PAGE_W   = 5,
  parameter int CHR_BITS = 6,
  localparam int PRG_AW  = PAGE_W + 15,
  localparam int CHR_AW  = CHR_BITS + 13
) (
  input  logic [14:0]         cpu_lo,
  input  logic [12:0]         ppu_a,
  input  mirror_e             mir_q,
  input  bank_mode_e          mode_q,
  input  logic                half_q,
  input  logic [PAGE_W-1:0]   page_q,
  input  logic [CHR_BITS-1:0] chr_q,
  output logic [PRG_AW-1:0]   prg_addr,
  output logic [CHR_AW-1:0]   chr_addr,
  output logic                vram_a10
);
  logic a14_sel;
  assign a14_sel  = pick_a14(mode_q, half_q, cpu_lo[14]);
  assign prg_addr = {page_q, a14_sel, cpu_lo[13:0]};
  assign chr_addr = {chr_q, ppu_a};
  assign vram_a10 = pick_a10(mir_q, ppu_a[10], ppu_a[11]);
endmodule

// File: rtl/addr_bank_mapper.sv
module addr_bank_mapper
  import mapper_pkg::*;
#(
  parameter int PAGE_BITS = 5,
  parameter int CHR_BITS  = 6,
  parameter bit WIDE_PRG  = 1'b0,
  localparam int PAGE_W   = PAGE_BITS + (WIDE_PRG ? 1 : 0),
  localparam int PRG_AW   = PAGE_W + 15,
  localparam int CHR_AW   = CHR_BITS + 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_a,
  input  logic              cpu_rw,
  input  logic              cpu_wr_stb,
  input  logic [12:0]       ppu_a,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              vram_a10
);
  // Named event for the checker: a write into the upper window.
  logic load_ev;
  assign load_ev = cpu_wr_stb && !cpu_rw && cpu_a[WIN_BIT];

  mirror_e             mir_d, mir_q;
  bank_mode_e          mode_d, mode_q;
  logic                half_d, half_q;
  logic [PAGE_W-1:0]   page_d, page_q;
  logic [CHR_BITS-1:0] chr_d, chr_q;

  mapper_decode #(.PAGE_BITS(PAGE_BITS), .CHR_BITS(CHR_BITS), .WIDE_PRG(WIDE_PRG)) u_dec (
    .wr_addr(cpu_a), .mir_d(mir_d), .mode_d(mode_d), .half_d(half_d),
    .page_d(page_d), .chr_d(chr_d)
  );

  mapper_state #(.PAGE_W(PAGE_W), .CHR_BITS(CHR_BITS)) u_st (
    .clk(clk), .rst_n(rst_n), .load(load_ev),
    .mir_d(mir_d), .mode_d(mode_d), .half_d(half_d), .page_d(page_d), .chr_d(chr_d),
    .mir_q(mir_q), .mode_q(mode_q), .half_q(half_q), .page_q(page_q), .chr_q(chr_q)
  );

  mapper_xlate #(.PAGE_W(PAGE_W), .CHR_BITS(CHR_BITS)) u_xl (
    .cpu_lo(cpu_a[14:0]), .ppu_a(ppu_a),
    .mir_q(mir_q), .mode_q(mode_q), .half_q(half_q), .page_q(page_q), .chr_q(chr_q),
    .prg_addr(prg_addr), .chr_addr(chr_addr), .vram_a10(vram_a10)
  );
endmodule

// File: rtl/addr_bank_mapper_chk.sv
module addr_bank_mapper_chk #(
  parameter int PAGE_BITS = 5,
  parameter int CHR_BITS  = 6,
  parameter int PAGE_W    = 5,
  parameter int PRG_AW    = 20,
  parameter int CHR_AW    = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_a,
  input logic              cpu_rw,
  input logic              cpu_wr_stb,
  input logic [12:0]       ppu_a,
  input logic [PRG_AW-1:0] prg_addr,
  input logic [CHR_AW-1:0] chr_addr,
  input logic              vram_a10,
  input logic              mir_bit,
  input logic              mode_bit,
  input logic              half_bit,
  input logic [PAGE_W-1:0] page_q,
  input logic [CHR_BITS-1:0] chr_q
);
  // R3
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr_stb && !cpu_rw && cpu_a[15]) |=> $stable({mir_bit, mode_bit, half_bit, page_q, chr_q}));
  // R2
  chr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_stb && !cpu_rw && cpu_a[15]) |=> chr_q == $past(cpu_a[CHR_BITS-1:0]));
  // R5
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_stb && !cpu_rw && cpu_a[15]) |=> page_q[PAGE_BITS-1:0] == $past(cpu_a[7 +: PAGE_BITS]));
  // R4
  mirror_vert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mir_bit |-> vram_a10 == ppu_a[10]);
  // R4
  mirror_horz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mir_bit |-> vram_a10 == ppu_a[11]);
  // R6
  half_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bit |-> prg_addr[14] == half_bit);
  // R7
  full_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_bit |-> prg_addr[14] == cpu_a[14]);
  // R8
  chr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chr_addr[12:0] == ppu_a && chr_addr[CHR_AW-1:13] == chr_q);
  // R9
  prg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prg_addr[13:0] == cpu_a[13:0]);
endmodule

bind addr_bank_mapper addr_bank_mapper_chk #(
  .PAGE_BITS(PAGE_BITS), .CHR_BITS(CHR_BITS), .PAGE_W(PAGE_W),
  .PRG_AW(PRG_AW), .CHR_AW(CHR_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_a(cpu_a), .cpu_rw(cpu_rw), .cpu_wr_stb(cpu_wr_stb),
  .ppu_a(ppu_a), .prg_addr(prg_addr), .chr_addr(chr_addr), .vram_a10(vram_a10),
  .mir_bit(mir_q), .mode_bit(mode_q), .half_bit(half_q), .page_q(page_q), .chr_q(chr_q)
);

// File: tb/addr_bank_mapper_tb.sv
`timescale 1ns/1ps
module addr_bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_a = 16'h0000;
  logic        cpu_rw = 1'b1;
  logic        cpu_wr_stb = 1'b0;
  logic [12:0] ppu_a = 13'h0;
  logic [19:0] prg_addr;
  logic [18:0] chr_addr;
  logic        vram_a10;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Model state, rebuilt from the requirement text.
  bit       m_horz, m_16k, m_half;
  bit [4:0] m_page;
  bit [5:0] m_chr;

  always #2.5 clk = ~clk;

  addr_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_a(cpu_a), .cpu_rw(cpu_rw), .cpu_wr_stb(cpu_wr_stb),
    .ppu_a(ppu_a), .prg_addr(prg_addr), .chr_addr(chr_addr), .vram_a10(vram_a10)
  );

  function automatic bit [19:0] want_prg(bit [15:0] a);
    bit b14;
    if (m_16k) b14 = m_half; else b14 = a[14];
    return {m_page, b14, a[13:0]};
  endfunction

  function automatic bit [18:0] want_chr(bit [12:0] p);
    return {m_chr, p};
  endfunction

  function automatic bit want_a10(bit [12:0] p);
    if (m_horz) return p[11];
    return p[10];
  endfunction

  task automatic model_load(bit [15:0] a);
    m_horz = a[13];
    m_16k  = a[12];
    m_page = a[11:7];
    m_half = a[6];
    m_chr  = a[5:0];
  endtask

  task automatic cmp(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive a bus cycle on the falling edge, then release it after the rising edge.
  task automatic bus(bit [15:0] a, bit rw);
    @(negedge clk);
    cpu_a = a; cpu_rw = rw; cpu_wr_stb = 1'b1;
    @(negedge clk);
    cpu_wr_stb = 1'b0; cpu_rw = 1'b1;
  endtask

  // Probe outputs with the strobe low.
  task automatic probe(string req, bit [15:0] a, bit [12:0] p);
    cpu_a = a; ppu_a = p;
    #1;
    cmp(req, 32'(prg_addr), 32'(want_prg(a)));
    cmp(req, 32'(chr_addr), 32'(want_chr(p)));
    cmp(req, 32'(vram_a10), 32'(want_a10(p)));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_load(16'h8000);
    #1;
    // R1: during reset
    probe("R1", 16'hC123, 13'h0C00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    probe("R1", 16'h8ABC, 13'h0800);
    probe("R1", 16'hFFFF, 13'h1FFF);

    // R2, R4, R5, R8: horizontal, 32K, page 0x15, chr 0x2A
    bus(16'h8000 | 16'h2000 | (16'h15 << 7) | 16'h2A, 1'b0);
    model_load(16'h8000 | 16'h2000 | (16'h15 << 7) | 16'h2A);
    probe("R2", 16'hC000, 13'h0800);
    probe("R4", 16'h8000, 13'h0400);
    cmp("R5", 32'(prg_addr[19:15]), 32'h15);
    cmp("R8", 32'(chr_addr[18:13]), 32'h2A);

    // R6: 16K mode, upper half; same half at $8000 and $C000
    bus(16'h9000 | (16'h1F << 7) | 16'h40 | 16'h3F, 1'b0);
    model_load(16'h9000 | (16'h1F << 7) | 16'h40 | 16'h3F);
    probe("R6", 16'h8000, 13'h0);
    cmp("R6", 32'(prg_addr[14]), 32'h1);
    probe("R6", 16'hC000, 13'h0);
    cmp("R6", 32'(prg_addr[14]), 32'h1);

    // R7: 32K mode with bit 6 set is ignored
    bus(16'h8040, 1'b0);
    model_load(16'h8040);
    probe("R7", 16'h8000, 13'h0);
    cmp("R7", 32'(prg_addr[14]), 32'h0);
    probe("R7", 16'hC000, 13'h0);
    cmp("R7", 32'(prg_addr[14]), 32'h1);

    // R9: bit 14 of the write address has no effect
    bus(16'hC000 | (16'h3 << 7) | 16'h05, 1'b0);
    model_load(16'hC000 | (16'h3 << 7) | 16'h05);
    probe("R9", 16'h8000, 13'h0123);
    cmp("R9", 32'(prg_addr[19:15]), 32'h3);

    // R3: read in upper window and write below $8000 leave state
    bus(16'hFFFF, 1'b1);
    probe("R3", 16'h8000, 13'h0C00);
    bus(16'h7FFF, 1'b0);
    probe("R3", 16'h8000, 13'h0C00);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned kind;
      bit [15:0] a;
      kind = $urandom_range(0, 9);
      a = 16'($urandom);
      if (kind < 6) begin
        a[15] = 1'b1;
        bus(a, 1'b0);
        model_load(a);
        probe("R2", 16'($urandom), 13'($urandom));
      end else if (kind < 8) begin
        a[15] = 1'b1;
        bus(a, 1'b1);
        probe("R3", 16'($urandom), 13'($urandom));
      end else begin
        a[15] = 1'b0;
        bus(a, 1'b0);
        probe("R3", 16'($urandom), 13'($urandom));
      end
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule